// File: doc/BRIEF.md
# Peak-Hold Swept Trace Recorder

This block records one swept trace into an on-chip table of 1024 words of 8 bits. Every clock it receives a digitized horizontal position code (10 bits) and a digitized amplitude sample (8 bits). While the position code holds its value, the block keeps the largest amplitude seen so far. When the code moves to a new value, the held maximum is written into the table entry for the position that just ended. Tracking then restarts from the sample taken in the boundary cycle. A sweep runs from code 0 to the all-ones code 1023, so one full sweep refreshes every entry.

Capture runs only while `sweep_en` is high. When `sweep_en` drops, the open segment is flushed into the table with one final write. At the end of a normal sweep this segment is address 1023. The table is written through an internal active-low write strobe. A separate read port reads it without changing it, for example for a display scanner. Read data appears one cycle after the read address.

Top module: `peak_trace_capture`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `rd_word` is 0.
- R2: The word stored for a position is the largest amplitude of all consecutive samples presented with that position code while `sweep_en` is high. A second sample with the same code never lowers it.
- R3: On the first cycle where `pos_code` differs from the code of the open segment, the held peak is written to the old position. The new segment's peak starts from that cycle's `amp_in`, not from zero.
- R4: When `sweep_en` is low on a clock edge and a segment is open, that segment's peak is written to its position and the segment closes. After a full sweep this stores position 1023.
- R5: While `sweep_en` is low and no segment is open, changes on `pos_code` and `amp_in` leave every stored word unchanged.
- R6: Reading is non-destructive. Repeated reads of the same address with no intervening capture return the same word.
- R7: `rd_word` shows the word at the `rd_addr` sampled on the previous rising clock edge.
- R8: A later sweep replaces each position it visits with the new peak, even when the new peak is smaller than the old word.
- R9: A sweep that begins at code 0 with no segment open stores position 0 from its own samples. A segment of a single sample stores that sample.
- R10: Positions that a sweep does not visit keep their previous words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sweep_en | input | 1 | High while a sweep is capturing |
| pos_code | input | 10 | Digitized horizontal position, non-decreasing within a sweep |
| amp_in | input | 8 | Digitized amplitude sample |
| rd_addr | input | 10 | Read address for the display side |
| rd_word | output | 8 | Stored word at the previous cycle's `rd_addr` |

## Verification
A wrong peak register shows as a stored word that is lower than some sample in its segment, or higher than all of them. This appears on the read port as soon as the sweep ends and the entry is read back. A boundary detector that loads zero instead of the current sample loses the first sample of every segment. A missing flush leaves the last position holding stale data from the previous sweep. Both faults become visible at the ports on the first readout after a sweep, and the random repeat counts make sure segments of length one are among those read.

// File: rtl/peak_trace_pkg.sv
package peak_trace_pkg;

  localparam int unsigned DEF_POS_W = 10;
  localparam int unsigned DEF_AMP_W = 8;

  typedef enum logic [0:0] {
    SEG_IDLE = 1'b0,
    SEG_OPEN = 1'b1
  } seg_state_e;

endpackage

// File: rtl/trace_bitplane.sv
module trace_bitplane #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic plane_q [DEPTH];

  // Storage cell array: written only while the strobe is low.
  always_ff @(posedge clk) begin
    if (!wr_n) begin
      plane_q[wr_addr] <= wr_bit;
    end
  end

  assign rd_bit = plane_q[rd_addr];

endmodule

// File: rtl/trace_ram.sv
module trace_ram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] plane_rd;
  logic [DATA_W-1:0] rd_data_d;
  logic              arm_q;
  logic              arm_d;

  // One single-bit plane per data bit.
  for (genvar b = 0; b < DATA_W; b++) begin : g_plane
    trace_bitplane #(
      .ADDR_W (ADDR_W)
    ) i_plane (
      .clk     (clk),
      .wr_n    (wr_n),
      .wr_addr (wr_addr),
      .wr_bit  (wr_data[b]),
      .rd_addr (rd_addr),
      .rd_bit  (plane_rd[b])
    );
  end

  always_comb begin
    rd_data_d = plane_rd;
    arm_d     = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      arm_q   <= 1'b0;
    end else begin
      rd_data <= rd_data_d;
      arm_q   <= arm_d;
    end
  end

  // Without a write and with the address held, the read word must not move.
  AST_READ_NONDESTRUCTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && $past(arm_q) && $past(wr_n) && $stable(rd_addr)) |=> (rd_data == $past(rd_data))); // R6

endmodule

// File: rtl/peak_segment_tracker.sv
module peak_segment_tracker
  import peak_trace_pkg::*;
#(
  parameter int unsigned POS_W = DEF_POS_W,
  parameter int unsigned AMP_W = DEF_AMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sweep_en,
  input  logic [POS_W-1:0] pos_code,
  input  logic [AMP_W-1:0] amp_in,
  output logic             wr_n,
  output logic [POS_W-1:0] wr_addr,
  output logic [AMP_W-1:0] wr_data
);

  seg_state_e       state_q, state_d;
  logic [POS_W-1:0] pos_q,   pos_d;
  logic [AMP_W-1:0] peak_q,  peak_d;
  logic             seg_en;
  logic             boundary;
  logic             same_pos;

  assign same_pos = (pos_code == pos_q);
  assign boundary = (state_q == SEG_OPEN) && sweep_en && !same_pos;
  assign seg_en   = sweep_en || (state_q == SEG_OPEN);

  // Next-state logic for the open segment and the write strobe.
  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    peak_d  = peak_q;
    wr_n    = 1'b1;
    wr_addr = pos_q;
    wr_data = peak_q;
    if (sweep_en) begin
      if (state_q == SEG_IDLE) begin
        state_d = SEG_OPEN;
        pos_d   = pos_code;
        peak_d  = amp_in;
      end else if (boundary) begin
        wr_n   = 1'b0;
        pos_d  = pos_code;
        peak_d = amp_in;
      end else if (amp_in > peak_q) begin
        peak_d = amp_in;
      end
    end else if (state_q == SEG_OPEN) begin
      wr_n    = 1'b0;
      state_d = SEG_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEG_IDLE;
      pos_q   <= '0;
      peak_q  <= '0;
    end else if (seg_en) begin
      state_q <= state_d;
      pos_q   <= pos_d;
      peak_q  <= peak_d;
    end
  end

  AST_PEAK_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEG_OPEN && sweep_en && same_pos) |=> (peak_q >= $past(peak_q))); // R2

  AST_PEAK_COVERS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEG_OPEN && sweep_en && same_pos) |=> (peak_q >= $past(amp_in))); // R2

  AST_BOUNDARY_SEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (peak_q == $past(amp_in) && pos_q == $past(pos_code))); // R3

  AST_WRITE_CLOSES_OR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n) |=> (state_q == SEG_IDLE || pos_q != $past(pos_q))); // R4

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEG_IDLE) |-> wr_n); // R5

endmodule

// File: rtl/peak_trace_capture.sv
module peak_trace_capture
  import peak_trace_pkg::*;
#(
  parameter int unsigned POS_W = DEF_POS_W,
  parameter int unsigned AMP_W = DEF_AMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sweep_en,
  input  logic [POS_W-1:0] pos_code,
  input  logic [AMP_W-1:0] amp_in,
  input  logic [POS_W-1:0] rd_addr,
  output logic [AMP_W-1:0] rd_word
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             wr_n;
  logic [POS_W-1:0] wr_addr;
  logic [AMP_W-1:0] wr_data;

  // Reset asserts at once and releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  peak_segment_tracker #(
    .POS_W (POS_W),
    .AMP_W (AMP_W)
  ) i_tracker (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sweep_en (sweep_en),
    .pos_code (pos_code),
    .amp_in   (amp_in),
    .wr_n     (wr_n),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  trace_ram #(
    .ADDR_W (POS_W),
    .DATA_W (AMP_W)
  ) i_ram (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_n    (wr_n),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_word)
  );

  AST_RESET_WORD_ZERO: assert property (@(posedge clk)
    (!rst_int_n) |=> (rd_word == '0)); // R1

endmodule

// File: tb/test_peak_trace_capture.sv
`timescale 1ns/1ps
module test_peak_trace_capture;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sweep_en;
  logic [9:0] pos_code;
  logic [7:0] amp_in;
  logic [9:0] rd_addr;
  logic [7:0] rd_word;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic [7:0] exp_mem [1024];
  bit         m_open;
  logic [9:0] m_pos;
  logic [7:0] m_peak;

  always #2 clk = ~clk;

  peak_trace_capture i_peak_trace_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .sweep_en (sweep_en),
    .pos_code (pos_code),
    .amp_in   (amp_in),
    .rd_addr  (rd_addr),
    .rd_word  (rd_word)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic [7:0] max8(input logic [7:0] a, input logic [7:0] b);
    return (a > b) ? a : b;
  endfunction

  // Drive one cycle of capture input and update the model from the requirements.
  task automatic drive(input bit act, input logic [9:0] p, input logic [7:0] a);
    @(negedge clk);
    sweep_en = act;
    pos_code = p;
    amp_in   = a;
    if (act) begin
      if (!m_open) begin
        m_open = 1'b1; m_pos = p; m_peak = a;
      end else if (p != m_pos) begin
        exp_mem[m_pos] = m_peak;
        m_pos = p; m_peak = a;
      end else begin
        m_peak = max8(m_peak, a);
      end
    end else if (m_open) begin
      exp_mem[m_pos] = m_peak;
      m_open = 1'b0;
    end
    @(posedge clk);
  endtask

  task automatic read_word(input logic [9:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    #1 v = rd_word;
  endtask

  task automatic read_all(input string req);
    logic [7:0] v;
    for (int a = 0; a < 1024; a++) begin
      read_word(a[9:0], v);
      check(req, v, exp_mem[a]);
    end
  endtask

  // Full sweep 0..1023, 1-3 samples per position, amplitude below limit.
  task automatic full_sweep(input int amp_lim);
    for (int p = 0; p < 1024; p++) begin
      int reps = 1 + int'($urandom_range(2));
      for (int r = 0; r < reps; r++) begin
        drive(1'b1, p[9:0], 8'($urandom_range(amp_lim)));
      end
    end
    drive(1'b0, 10'd1023, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    void'($urandom(32'd1234));
    m_open = 1'b0; m_pos = '0; m_peak = '0;
    rst_n = 1'b0; sweep_en = 1'b0; pos_code = '0; amp_in = '0; rd_addr = '0;
    repeat (4) @(posedge clk);
    #1 check("R1", rd_word, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1 check("R1", rd_word, 8'd0);
    repeat (3) @(posedge clk);

    // R9 and R2/R3: first sweep fills every position, ends with flush R4.
    full_sweep(255);
    read_all("R2/R3/R9 first sweep");
    read_word(10'd1023, v);
    check("R4 flush of position 1023", v, exp_mem[1023]);
    read_word(10'd0, v);
    check("R9 position 0", v, exp_mem[0]);

    // Directed partial sweep: peak mid-segment, seeded-from-sample, flush.
    drive(1'b1, 10'd5, 8'd10);
    drive(1'b1, 10'd5, 8'd200);
    drive(1'b1, 10'd5, 8'd30);
    drive(1'b1, 10'd6, 8'd50);   // first sample of segment 6 is its peak
    drive(1'b1, 10'd6, 8'd20);
    drive(1'b1, 10'd7, 8'd99);   // single sample, flushed
    drive(1'b0, 10'd7, 8'd0);
    read_word(10'd5, v);  check("R2 peak in middle", v, 8'd200);
    read_word(10'd6, v);  check("R3 seed from boundary sample", v, 8'd50);
    read_word(10'd7, v);  check("R4 flush on sweep end", v, 8'd99);
    read_word(10'd4, v);  check("R10 unvisited below", v, exp_mem[4]);
    read_word(10'd8, v);  check("R10 unvisited above", v, exp_mem[8]);

    // Extremes: all-zero segment and peak as last sample.
    drive(1'b1, 10'd20, 8'd0);
    drive(1'b1, 10'd20, 8'd0);
    drive(1'b1, 10'd21, 8'd1);
    drive(1'b1, 10'd21, 8'd255);
    drive(1'b1, 10'd22, 8'd3);
    drive(1'b0, 10'd22, 8'd0);
    read_word(10'd20, v); check("R2 all-zero segment", v, 8'd0);
    read_word(10'd21, v); check("R2 peak on last sample", v, 8'd255);
    read_word(10'd22, v); check("R9 single-sample segment", v, 8'd3);

    // R5: idle noise must not touch storage.
    for (int i = 0; i < 64; i++) begin
      drive(1'b0, 10'($urandom_range(1023)), 8'($urandom_range(255)));
    end
    read_all("R5 idle inputs ignored");

    // R6: repeated reads of one address.
    read_word(10'd5, v);
    read_word(10'd5, v2);
    check("R6 repeat read", v2, v);
    repeat (5) @(posedge clk);
    #1 check("R6 held read", rd_word, 8'd200);

    // R7: address changes every cycle, word follows one cycle later.
    read_word(10'd21, v); check("R7 latency a", v, 8'd255);
    read_word(10'd20, v); check("R7 latency b", v, 8'd0);
    read_word(10'd6, v);  check("R7 latency c", v, 8'd50);

    // R8: second sweep with small amplitudes replaces larger old words.
    full_sweep(15);
    read_all("R8 second sweep overwrites");
    read_word(10'd21, v); check("R8 smaller value replaces 255", v, exp_mem[21]);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule